// File: doc/BRIEF.md
# Serial NOR Memory Command Slave

This block is an SPI mode-0 target that acts like a small serial NOR memory. A host drives the serial clock, chip select and data-in lines. Everything on them is shifted most significant bit first, and the host reads replies on the data-out line. The block holds a byte array split into pages and a status byte. The status byte has a write-enable flag and a protect bit. Five opcodes are decoded: arm writes, write the status byte, program a page, stream memory out and stream status out.

The block samples the three serial inputs and the write-protect pin with a system clock, through a synchronizer. Each serial clock half-period must therefore last several system clocks. A write command only takes effect if an earlier frame armed the write-enable flag. Programming stays inside the addressed page and wraps within it. Reading runs linearly across the whole array.

Top module: `spi_nor_slave`

## Requirements
- R1: Opcode, address and data bits are taken on rising serial-clock edges, most significant bit first. Reply bits change after falling edges, and the first reply bit of a byte appears after the falling edge that follows the previous byte's eighth rising edge.
- R2: Opcode 0x06 sets the write-enable flag at chip-select rise, and only when the frame held exactly eight bits. A 0x06 frame with any further bit leaves the flag unchanged.
- R3: Opcodes 0x01 and 0x02 received while the write-enable flag is clear change neither memory nor the status byte.
- R4: An accepted 0x01 or 0x02 command clears the write-enable flag when chip select rises at the end of that frame.
- R5: Each complete data byte after an accepted 0x01 copies its bits 7..2 into status bits 7..2. Status bit 1 is the write-enable flag and status bit 0 always reads 0.
- R6: Opcode 0x02 takes a three-byte address, high byte first, followed by data bytes. Only the low 8 address bits are used with the default 256-byte array. The frame 0x02,0x01,0x2F,0xEF,0xD8 stores 0xD8 at address 0xEF (the alias of 0x012FEF).
- R7: Programming starts at any offset in the page and wraps within the 8-byte page. With a start at offset 4, bytes 0..7 land as 4,5,6,7,0,1,2,3 at offsets 0..7.
- R8: Opcode 0x03 with a three-byte address streams memory bytes on MISO. The address increments across page boundaries and wraps from the last array byte to byte 0.
- R9: Opcode 0x05 returns the status byte on MISO for every byte the host clocks.
- R10: While status bit 7 is set and wp_n is low, 0x01 and 0x02 leave memory, status bits and the write-enable flag unchanged.
- R11: If chip select rises mid-byte, the partial byte is discarded, and data bytes already completed in that frame stay written.
- R12: After reset the status byte reads 0x00, and MISO is 0 whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host (mode 0) |
| cs_n | input | 1 | Active-low chip select that frames one command |
| mosi | input | 1 | Serial data from host, MSB first |
| wp_n | input | 1 | Active-low write-protect pin, effective when status bit 7 is set |
| miso | output | 1 | Serial data to host, MSB first |

## Verification
Most internal faults surface one frame late at the ports. A flag or status bit held wrongly shows up only when a later 0x05 frame reads it, or when a later write is wrongly taken or wrongly refused and a 0x03 frame reads the bytes back. An address counter that wraps at the wrong bit becomes visible only in a read of the neighbouring page, or across the array end. For that reason, every write in the bench is followed by a read of the affected bytes and the status byte. The MISO line is also compared with zero on every clock while the part is deselected.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;
  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_PROG, PH_WSTAT, PH_READ, PH_RSTAT, PH_SKIP
  } phase_t;

  localparam logic [7:0] OPC_ARM   = 8'h06;
  localparam logic [7:0] OPC_WSTAT = 8'h01;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_RSTAT = 8'h05;
  localparam int         ADDR_BYTES = 3;
endpackage

// File: rtl/spi_nor_sync.sv
module spi_nor_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  input  logic wp_n,
  output logic rst_sync_n,
  output logic cs_n_s,
  output logic mosi_s,
  output logic wp_n_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise
);
  localparam int         LW      = 4;
  localparam logic [LW-1:0] IDLE_V = 4'b1100; // {wp_n, cs_n, mosi, sclk}

  logic [STAGES-1:0]         rst_pipe;
  logic [STAGES-1:0][LW-1:0] pipe;
  logic [LW-1:0]             cur;
  logic                      sclk_prev, cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pipe      <= {STAGES{IDLE_V}};
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b1;
    end else begin
      pipe      <= {pipe[STAGES-2:0], {wp_n, cs_n, mosi, sclk}};
      sclk_prev <= cur[0];
      cs_prev   <= cur[2];
    end
  end

  assign cur       = pipe[STAGES-1];
  assign mosi_s    = cur[1];
  assign cs_n_s    = cur[2];
  assign wp_n_s    = cur[3];
  assign sclk_rise = cur[0] & ~sclk_prev;
  assign sclk_fall = ~cur[0] & sclk_prev;
  assign cs_rise   = cur[2] & ~cs_prev;
endmodule

// File: rtl/spi_nor_array.sv
module spi_nor_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_nor_slave.sv
module spi_nor_slave
  import spi_nor_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  localparam int           BIT_W   = 3;
  localparam logic [BIT_W-1:0] LAST_BIT = 3'd7;
  localparam logic [1:0]   LAST_ADR = 2'(ADDR_BYTES - 1);

  logic rst_sync_n, cs_n_s, mosi_s, wp_n_s, sclk_rise, sclk_fall, cs_rise;

  spi_nor_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .wp_n(wp_n),
    .rst_sync_n(rst_sync_n), .cs_n_s(cs_n_s), .mosi_s(mosi_s), .wp_n_s(wp_n_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_rise(cs_rise)
  );

  phase_t            ph_q, ph_d;
  logic [7:0]        opc_q, opc_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [6:0]        shin_q, shin_d;
  logic [1:0]        acnt_q, acnt_d;
  logic [1:0]        bcnt_q, bcnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_shift;
  logic              wel_q, wel_d;
  logic [5:0]        sbits_q, sbits_d;
  logic              acc_q, acc_d;
  logic [7:0]        tx_q, tx_d;
  logic              ld_q, ld_d;

  logic       byte_done, locked, mem_we, stat_we;
  logic [7:0] rx_byte, status, rdata, next_tx;

  assign byte_done = sclk_rise & ~cs_n_s & (bit_q == LAST_BIT);
  assign rx_byte   = {shin_q, mosi_s};
  assign locked    = sbits_q[5] & ~wp_n_s;
  assign status    = {sbits_q, wel_q, 1'b0};
  assign mem_we    = byte_done & (ph_q == PH_PROG) & ~locked;
  assign stat_we   = byte_done & (ph_q == PH_WSTAT) & ~locked;

  // address shifter: keep the low ADDR_W bits of the 24-bit address
  if (ADDR_W > 8) begin : g_wide
    assign addr_shift = {addr_q[ADDR_W-9:0], rx_byte};
  end else if (ADDR_W == 8) begin : g_byte
    assign addr_shift = rx_byte;
  end else begin : g_narrow
    assign addr_shift = rx_byte[ADDR_W-1:0];
  end

  spi_nor_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(addr_q), .wdata(rx_byte),
    .raddr(addr_q), .rdata(rdata)
  );

  always_comb begin
    unique case (ph_q)
      PH_READ:  next_tx = rdata;
      PH_RSTAT: next_tx = status;
      default:  next_tx = 8'h00;
    endcase
  end

  // next-state logic
  always_comb begin
    ph_d = ph_q; opc_d = opc_q; bit_d = bit_q; shin_d = shin_q;
    acnt_d = acnt_q; bcnt_d = bcnt_q; addr_d = addr_q; wel_d = wel_q;
    sbits_d = sbits_q; acc_d = acc_q; tx_d = tx_q; ld_d = ld_q;

    if (cs_rise) begin
      if (opc_q == OPC_ARM && bcnt_q == 2'd1 && bit_q == '0) wel_d = 1'b1;
      else if (acc_q)                                         wel_d = 1'b0;
    end
    if (stat_we) sbits_d = rx_byte[7:2];

    if (cs_n_s) begin
      ph_d = PH_OPC; bit_d = '0; acnt_d = '0; bcnt_d = '0;
      acc_d = 1'b0; tx_d = '0; ld_d = 1'b0;
    end else begin
      if (sclk_rise) begin
        bit_d  = bit_q + 1'b1;
        shin_d = {shin_q[5:0], mosi_s};
      end
      if (byte_done) begin
        ld_d = 1'b1;
        if (bcnt_q != 2'd3) bcnt_d = bcnt_q + 1'b1;
        unique case (ph_q)
          PH_OPC: begin
            opc_d = rx_byte;
            unique case (rx_byte)
              OPC_PROG:  if (wel_q && !locked) begin ph_d = PH_ADDR; acc_d = 1'b1; end
                         else ph_d = PH_SKIP;
              OPC_WSTAT: if (wel_q && !locked) begin ph_d = PH_WSTAT; acc_d = 1'b1; end
                         else ph_d = PH_SKIP;
              OPC_READ:  ph_d = PH_ADDR;
              OPC_RSTAT: ph_d = PH_RSTAT;
              default:   ph_d = PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            addr_d = addr_shift;
            acnt_d = acnt_q + 1'b1;
            if (acnt_q == LAST_ADR) ph_d = (opc_q == OPC_PROG) ? PH_PROG : PH_READ;
          end
          PH_PROG: addr_d = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
          PH_READ: addr_d = addr_q + 1'b1;
          default: ;
        endcase
      end
      if (sclk_fall) begin
        if (ld_q) begin tx_d = next_tx; ld_d = 1'b0; end
        else      tx_d = {tx_q[6:0], 1'b0};
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ph_q <= PH_OPC; opc_q <= '0; bit_q <= '0; shin_q <= '0; acnt_q <= '0;
      bcnt_q <= '0; addr_q <= '0; wel_q <= 1'b0; sbits_q <= '0; acc_q <= 1'b0;
      tx_q <= '0; ld_q <= 1'b0;
    end else begin
      ph_q <= ph_d; opc_q <= opc_d; bit_q <= bit_d; shin_q <= shin_d;
      acnt_q <= acnt_d; bcnt_q <= bcnt_d; addr_q <= addr_d; acc_q <= acc_d;
      tx_q <= tx_d; ld_q <= ld_d; wel_q <= wel_d;
      if (stat_we) sbits_q <= sbits_d;
    end
  end

  assign miso = tx_q[7];

  // R3
  prog_wel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> wel_q);
  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(wel_q) |-> $past(cs_rise));
  // R7
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ph_q == PH_PROG && $past(ph_q == PH_PROG))
      |-> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));
  // R8
  read_inc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ph_q == PH_READ && $past(ph_q == PH_READ) && $past(byte_done))
      |-> addr_q == $past(addr_q) + 1'b1);
  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (locked && $past(locked)) |-> $stable(sbits_q));
endmodule

// File: tb/test_spi_nor_slave.sv
module test_spi_nor_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso;
  int   checks = 0, fails = 0, hi_cnt = 0;
  bit   done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_nor_slave i_spi_nor_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .wp_n(wp_n), .miso(miso)
  );

  // reference model state
  logic [7:0] m_mem [256];
  bit         m_ok  [256];
  logic       m_wel = 1'b0;
  logic [7:0] m_stat = 8'h00;
  logic [7:0] cmd [$];
  logic [7:0] rxq [$];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // R12: MISO idle while deselected, compared every clock
  always @(negedge clk) begin
    if (cs_n) hi_cnt++; else hi_cnt = 0;
    if (hi_cnt > 6 && !done) chk("R12", {7'b0, miso}, 8'h00);
  end

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk); mosi = tx[i];
      repeat (HALF - 1) @(negedge clk);
      rx[i] = miso; sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic model(input string req, input int tail);
    int  n = cmd.size();
    int  a;
    bit  lk = m_stat[7] && !wp_n;
    case (cmd[0])
      8'h06: if (n == 1 && tail == 0) m_wel = 1'b1;
      8'h01: if (m_wel && !lk) begin
        for (int i = 1; i < n; i++) m_stat = {cmd[i][7:2], 2'b00};
        m_wel = 1'b0;
      end
      8'h02: if (m_wel && !lk) begin
        a = (n >= 4) ? int'(cmd[3]) : 0;
        for (int i = 4; i < n; i++) begin
          m_mem[a] = cmd[i]; m_ok[a] = 1'b1;
          a = (a & 'hF8) | ((a + 1) & 7);
        end
        m_wel = 1'b0;
      end
      8'h03: begin
        a = int'(cmd[3]);
        for (int i = 4; i < n; i++) begin
          if (m_ok[a]) chk(req, rxq[i], m_mem[a]);
          a = (a + 1) & 255;
        end
      end
      8'h05: for (int i = 1; i < n; i++) chk(req, rxq[i], m_stat | {6'b0, m_wel, 1'b0});
      default: ;
    endcase
  endtask

  task automatic frame(input string req, input int tail);
    logic [7:0] r;
    rxq = {};
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    foreach (cmd[i]) begin xfer(cmd[i], 8, r); rxq.push_back(r); end
    if (tail > 0) xfer(8'hA5, tail, r);
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
    model(req, tail);
  endtask

  task automatic arm();
    cmd = {8'h06}; frame("R2", 0);
  endtask

  task automatic rstat(input string req);
    cmd = {8'h05, 8'h00, 8'h00}; frame(req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12", {7'b0, miso}, 8'h00);
    rstat("R12");

    // R2 / R4 / R1: arm, program, read back bit-order patterns
    arm(); rstat("R2");
    cmd = {8'h02, 8'h00, 8'h00, 8'h10, 8'h80, 8'h01, 8'h5A, 8'hC3}; frame("R6", 0);
    rstat("R4");
    cmd = {8'h03, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00}; frame("R1", 0);

    // R3: writes without the flag
    cmd = {8'h02, 8'h00, 8'h00, 8'h10, 8'hEE}; frame("R3", 0);
    cmd = {8'h01, 8'hFF}; frame("R3", 0);
    cmd = {8'h03, 8'h00, 8'h00, 8'h10, 8'h00}; frame("R3", 0);
    rstat("R3");

    // R2: arm frame with an extra byte, and with extra bits
    cmd = {8'h06, 8'h00}; frame("R2", 0); rstat("R2");
    cmd = {8'h06}; frame("R2", 3); rstat("R2");

    // R5 / R9: status write
    arm(); cmd = {8'h01, 8'hFF}; frame("R5", 0);
    cmd = {8'h05, 8'h00, 8'h00, 8'h00, 8'h00}; frame("R9", 0);

    // R10: protect with pin low
    arm(); wp_n = 1'b0;
    cmd = {8'h02, 8'h00, 8'h00, 8'h10, 8'h77}; frame("R10", 0);
    cmd = {8'h01, 8'h00}; frame("R10", 0);
    rstat("R10");
    cmd = {8'h03, 8'h00, 8'h00, 8'h10, 8'h00}; frame("R10", 0);
    wp_n = 1'b1;
    cmd = {8'h01, 8'h00}; frame("R5", 0); rstat("R5");

    // R6: address aliasing example
    arm(); cmd = {8'h02, 8'h01, 8'h2F, 8'hEF, 8'hD8}; frame("R6", 0);
    cmd = {8'h03, 8'h01, 8'h2F, 8'hEF, 8'h00}; frame("R6", 0);
    cmd = {8'h03, 8'h00, 8'h00, 8'hEF, 8'h00}; frame("R6", 0);

    // R7: page wrap from offset 4
    arm();
    cmd = {8'h02, 8'h00, 8'h00, 8'h24, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
    frame("R7", 0);
    cmd = {8'h03, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    frame("R7", 0);

    // R8: linear read across page and array end
    arm();
    cmd = {8'h02, 8'h00, 8'h00, 8'h28, 8'h18, 8'h19, 8'h1A, 8'h1B, 8'h1C, 8'h1D, 8'h1E, 8'h1F};
    frame("R8", 0);
    cmd = {8'h03, 8'h00, 8'h00, 8'h26, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; frame("R8", 0);
    arm();
    cmd = {8'h02, 8'h00, 8'h00, 8'hF8, 8'hF0, 8'hF1, 8'hF2, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hF7};
    frame("R8", 0);
    arm();
    cmd = {8'h02, 8'h00, 8'h00, 8'h00, 8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7};
    frame("R8", 0);
    cmd = {8'h03, 8'h00, 8'h00, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00}; frame("R8", 0);

    // R11: partial trailing byte
    arm();
    cmd = {8'h02, 8'h00, 8'h00, 8'h40, 8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37};
    frame("R11", 0);
    arm();
    cmd = {8'h02, 8'h00, 8'h00, 8'h40, 8'hB1, 8'hB2}; frame("R11", 4);
    cmd = {8'h03, 8'h00, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00}; frame("R11", 0);
    rstat("R4");

    finish_run();
  end
endmodule